// File: doc/BRIEF.md
# Branch Condition and Next-Index Unit

This block decides the control-flow outcome of one jump-group instruction for a 64-bit register machine. Each cycle it may accept the operation code, the operand-select bit, the width class, the destination and source register values, the 32-bit immediate, a signed 16-bit displacement and the index of the current instruction. One clock later it presents the result: whether the branch is taken, the index of the next instruction, and flags for a subroutine call, a program return and an illegal encoding.

A single 4-bit code space covers unsigned magnitude tests, signed magnitude tests, equality and a bit-test. A second class compares only the low 32 bits of both operands. Instruction indices count whole 64-bit instruction slots and wrap at the width of the index. Call and return are only flagged here. The stack and any helper dispatch belong to the caller.

Top module: `brx_branch_unit`

## Requirements
- R1: The outputs are registered. `out_valid` is high exactly one cycle after `in_valid` was high. While `out_valid` is low, `taken`, `is_call`, `is_exit` and `illegal` are all low, and reset clears every output to zero.
- R2: Code 0x1 is taken when the operands are equal. Code 0x5 is taken when they differ.
- R3: The unsigned codes are 0x2 (greater), 0x3 (greater or equal), 0xA (less) and 0xB (less or equal).
- R4: The signed two's-complement codes are 0x6 (greater), 0x7 (greater or equal), 0xC (less) and 0xD (less or equal).
- R5: Code 0x4 is taken when the bitwise AND of the operands is nonzero.
- R6: With `src_sel`=1 the second operand is `src_val`. With `src_sel`=0 it is the immediate, which the wide class (`is_jmp32`=0) sign-extends from bit 31 to 64 bits.
- R7: In the narrow class (`is_jmp32`=1) only bits 31:0 of both operands take part. Signed codes use bit 31 as the sign, and the immediate is used as-is.
- R8: Code 0x0 in the wide class is always taken.
- R9: When taken, `next_idx` = `cur_idx` + 1 + sign-extended `offset`. Otherwise it is `cur_idx` + 1. Both wrap modulo 2^PCW.
- R10: Code 0x8 (either class) raises `is_call`, and code 0x9 in the wide class raises `is_exit`. Neither is taken. At most one of `taken`, `is_call`, `is_exit` and `illegal` is high.
- R11: Code 0x0 or 0x9 in the narrow class, and codes 0xE or 0xF in either class, raise `illegal`. Such an instruction is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| op_code | input | 4 | Condition/operation code |
| src_sel | input | 1 | 1: register source, 0: immediate |
| is_jmp32 | input | 1 | 1: narrow 32-bit class, 0: wide 64-bit class |
| dst_val | input | XLEN | First operand (destination register) |
| src_val | input | XLEN | Source register operand |
| imm | input | IMMW | Immediate operand |
| offset | input | OFFW | Signed displacement in instruction slots |
| cur_idx | input | PCW | Index of the current instruction |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| next_idx | output | PCW | Index of the next instruction |
| is_call | output | 1 | Subroutine call |
| is_exit | output | 1 | Program return |
| illegal | output | 1 | Illegal encoding |

## Verification
The hardest cases to reach are narrow-class compares where the upper halves of the operands would give the opposite answer to the lower halves. Examples are a signed test where bit 63 and bit 31 disagree, and an immediate whose sign extension matters only in the wide class. Random operands almost never produce these. The bench therefore draws operands from a pool of boundary values (zero, one, all-ones, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF, 2^63) and mixes them with random values so that equal and near-equal pairs are common. Directed steps add displacement wrap at index zero and at the top of the index range.

// File: rtl/brx_pkg.sv
package brx_pkg;

    typedef enum logic [3:0] {
        OP_ALWAYS = 4'h0,
        OP_EQ     = 4'h1,
        OP_UGT    = 4'h2,
        OP_UGE    = 4'h3,
        OP_ANYB   = 4'h4,
        OP_NE     = 4'h5,
        OP_SGT    = 4'h6,
        OP_SGE    = 4'h7,
        OP_CALL   = 4'h8,
        OP_RET    = 4'h9,
        OP_ULT    = 4'hA,
        OP_ULE    = 4'hB,
        OP_SLT    = 4'hC,
        OP_SLE    = 4'hD
    } op_e;

    // Relation flags between two operands of one width
    typedef struct packed {
        logic eq;
        logic ult;
        logic slt;
        logic anyb;
    } rel_t;

endpackage

// File: rtl/brx_operand_mux.sv
module brx_operand_mux #(
    parameter int XLEN = 64,
    parameter int IMMW = 32
) (
    input  logic            src_sel,
    input  logic [XLEN-1:0] src_val,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] opb
);
    localparam int EXT = XLEN - IMMW;

    logic [XLEN-1:0] imm_wide;

    generate
        if (EXT > 0) begin : g_sext
            assign imm_wide = {{EXT{imm[IMMW-1]}}, imm};
        end else begin : g_trunc
            assign imm_wide = imm[XLEN-1:0];
        end
    endgenerate

    assign opb = src_sel ? src_val : imm_wide;
endmodule

// File: rtl/brx_rel_cmp.sv
module brx_rel_cmp
    import brx_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output rel_t         rel
);
    logic ult;

    assign ult = a < b;

    always_comb begin
        rel.eq   = (a == b);
        rel.ult  = ult;
        rel.slt  = (a[W-1] != b[W-1]) ? a[W-1] : ult;
        rel.anyb = |(a & b);
    end
endmodule

// File: rtl/brx_next_idx.sv
module brx_next_idx #(
    parameter int PCW  = 32,
    parameter int OFFW = 16
) (
    input  logic [PCW-1:0]  cur,
    input  logic [OFFW-1:0] off,
    output logic [PCW-1:0]  nxt_seq,
    output logic [PCW-1:0]  nxt_jmp
);
    localparam int EXT = PCW - OFFW;

    logic [PCW-1:0] off_ext;

    generate
        if (EXT > 0) begin : g_sext
            assign off_ext = {{EXT{off[OFFW-1]}}, off};
        end else begin : g_trunc
            assign off_ext = off[PCW-1:0];
        end
    endgenerate

    assign nxt_seq = cur + PCW'(1);
    assign nxt_jmp = nxt_seq + off_ext;
endmodule

// File: rtl/brx_branch_unit.sv
module brx_branch_unit
    import brx_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IMMW = 32,
    parameter int OFFW = 16,
    parameter int PCW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op_code,
    input  logic            src_sel,
    input  logic            is_jmp32,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [IMMW-1:0] imm,
    input  logic [OFFW-1:0] offset,
    input  logic [PCW-1:0]  cur_idx,
    output logic            out_valid,
    output logic            taken,
    output logic [PCW-1:0]  next_idx,
    output logic            is_call,
    output logic            is_exit,
    output logic            illegal
);
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic           vld;
        logic           take;
        logic           call;
        logic           ret;
        logic           bad;
        logic [PCW-1:0] nxt;
    } res_t;

    res_t res_d, res_q;

    logic [XLEN-1:0] opb;
    rel_t            rel_wide, rel_narrow, rel;
    logic [PCW-1:0]  nxt_seq, nxt_jmp;

    brx_operand_mux #(.XLEN(XLEN), .IMMW(IMMW)) u_opmux (
        .src_sel (src_sel),
        .src_val (src_val),
        .imm     (imm),
        .opb     (opb)
    );

    brx_rel_cmp #(.W(XLEN)) u_cmp_wide (
        .a   (dst_val),
        .b   (opb),
        .rel (rel_wide)
    );

    brx_rel_cmp #(.W(HALF)) u_cmp_narrow (
        .a   (dst_val[HALF-1:0]),
        .b   (opb[HALF-1:0]),
        .rel (rel_narrow)
    );

    brx_next_idx #(.PCW(PCW), .OFFW(OFFW)) u_next (
        .cur     (cur_idx),
        .off     (offset),
        .nxt_seq (nxt_seq),
        .nxt_jmp (nxt_jmp)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = in_valid;
        rel       = is_jmp32 ? rel_narrow : rel_wide;
        if (in_valid) begin
            unique case (op_code)
                OP_ALWAYS: begin
                    if (is_jmp32) res_d.bad  = 1'b1;
                    else          res_d.take = 1'b1;
                end
                OP_EQ:   res_d.take = rel.eq;
                OP_NE:   res_d.take = !rel.eq;
                OP_UGT:  res_d.take = !(rel.ult || rel.eq);
                OP_UGE:  res_d.take = !rel.ult;
                OP_ULT:  res_d.take = rel.ult;
                OP_ULE:  res_d.take = rel.ult || rel.eq;
                OP_SGT:  res_d.take = !(rel.slt || rel.eq);
                OP_SGE:  res_d.take = !rel.slt;
                OP_SLT:  res_d.take = rel.slt;
                OP_SLE:  res_d.take = rel.slt || rel.eq;
                OP_ANYB: res_d.take = rel.anyb;
                OP_CALL: res_d.call = 1'b1;
                OP_RET: begin
                    if (is_jmp32) res_d.bad = 1'b1;
                    else          res_d.ret = 1'b1;
                end
                default: res_d.bad = 1'b1;
            endcase
            res_d.nxt = res_d.take ? nxt_jmp : nxt_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign taken     = res_q.take;
    assign next_idx  = res_q.nxt;
    assign is_call   = res_q.call;
    assign is_exit   = res_q.ret;
    assign illegal   = res_q.bad;
endmodule

// File: rtl/brx_branch_chk.sv
module brx_branch_chk #(
    parameter int OFFW = 16,
    parameter int PCW  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [3:0]      op_code,
    input logic            is_jmp32,
    input logic [OFFW-1:0] offset,
    input logic [PCW-1:0]  cur_idx,
    input logic            out_valid,
    input logic            taken,
    input logic [PCW-1:0]  next_idx,
    input logic            is_call,
    input logic            is_exit,
    input logic            illegal
);
    logic [PCW-1:0] off_ext;
    assign off_ext = {{(PCW-OFFW){offset[OFFW-1]}}, offset};

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(taken || is_call || is_exit || illegal));

    assert_seq_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> next_idx == $past(cur_idx) + PCW'(1));

    assert_jump_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && taken) |-> next_idx == $past(cur_idx) + PCW'(1) + $past(off_ext));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({taken, is_call, is_exit, illegal}));

    assert_call_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'h8) |=> (is_call && !taken));

    assert_always_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 4'h0 && !is_jmp32) |=> taken);

    assert_narrow_bad_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_jmp32 && (op_code == 4'h0 || op_code == 4'h9)) |=> illegal);

    assert_unused_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code >= 4'hE) |=> (illegal && !taken));
endmodule

bind brx_branch_unit brx_branch_chk #(.OFFW(OFFW), .PCW(PCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .is_jmp32  (is_jmp32),
    .offset    (offset),
    .cur_idx   (cur_idx),
    .out_valid (out_valid),
    .taken     (taken),
    .next_idx  (next_idx),
    .is_call   (is_call),
    .is_exit   (is_exit),
    .illegal   (illegal)
);

// File: tb/sim_brx_branch_unit.sv
`timescale 1ns/1ps
module sim_brx_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        src_sel = 1'b0;
    logic        is_jmp32 = 1'b0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm = '0;
    logic [15:0] offset = '0;
    logic [31:0] cur_idx = '0;
    logic        out_valid, taken, is_call, is_exit, illegal;
    logic [31:0] next_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    brx_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .src_sel(src_sel), .is_jmp32(is_jmp32), .dst_val(dst_val),
        .src_val(src_val), .imm(imm), .offset(offset), .cur_idx(cur_idx),
        .out_valid(out_valid), .taken(taken), .next_idx(next_idx),
        .is_call(is_call), .is_exit(is_exit), .illegal(illegal)
    );

    // expected result of the previously driven input
    logic        e_vld = 1'b0, e_tk = 1'b0, e_call = 1'b0, e_ret = 1'b0, e_bad = 1'b0;
    logic [31:0] e_nxt = '0;
    string       e_tag = "R1";

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp, string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic string cond_tag(logic [3:0] c, logic nar, logic ss);
        string t;
        case (c)
            4'h1, 4'h5:               t = "R2";
            4'h2, 4'h3, 4'hA, 4'hB:   t = "R3";
            4'h6, 4'h7, 4'hC, 4'hD:   t = "R4";
            4'h4:                     t = "R5";
            4'h0:                     t = nar ? "R11" : "R8";
            4'h8, 4'h9:               t = (nar && c == 4'h9) ? "R11" : "R10";
            default:                  t = "R11";
        endcase
        if (nar) t = {t, "/R7"};
        else if (!ss) t = {t, "/R6"};
        return t;
    endfunction

    // behavioural reference model
    task automatic model();
        logic [63:0] b, ua, ub;
        longint sa, sb;
        logic t;
        b = src_sel ? src_val : {{32{imm[31]}}, imm};
        if (is_jmp32) begin
            ua = {32'd0, dst_val[31:0]};
            ub = {32'd0, b[31:0]};
            sa = longint'($signed(dst_val[31:0]));
            sb = longint'($signed(b[31:0]));
        end else begin
            ua = dst_val; ub = b;
            sa = $signed(dst_val); sb = $signed(b);
        end
        t = 1'b0; e_call = 1'b0; e_ret = 1'b0; e_bad = 1'b0;
        case (op_code)
            4'h0: if (is_jmp32) e_bad = 1'b1; else t = 1'b1;
            4'h1: t = (ua == ub);
            4'h5: t = (ua != ub);
            4'h2: t = (ua > ub);
            4'h3: t = (ua >= ub);
            4'hA: t = (ua < ub);
            4'hB: t = (ua <= ub);
            4'h6: t = (sa > sb);
            4'h7: t = (sa >= sb);
            4'hC: t = (sa < sb);
            4'hD: t = (sa <= sb);
            4'h4: t = ((ua & ub) != 0);
            4'h8: e_call = 1'b1;
            4'h9: if (is_jmp32) e_bad = 1'b1; else e_ret = 1'b1;
            default: e_bad = 1'b1;
        endcase
        e_tk  = t;
        e_nxt = t ? cur_idx + 32'd1 + {{16{offset[15]}}, offset} : cur_idx + 32'd1;
        e_vld = in_valid;
        e_tag = cond_tag(op_code, is_jmp32, src_sel);
    endtask

    task automatic compare();
        chk("R1", {63'd0, out_valid}, {63'd0, e_vld}, "out_valid");
        if (e_vld) begin
            chk(e_tag, {63'd0, taken}, {63'd0, e_tk}, "taken");
            chk("R9", {32'd0, next_idx}, {32'd0, e_nxt}, "next_idx");
            chk("R10", {61'd0, is_call, is_exit, taken & (is_call | is_exit)},
                {61'd0, e_call, e_ret, 1'b0}, "call/exit");
            chk("R11", {63'd0, illegal}, {63'd0, e_bad}, "illegal");
        end else begin
            chk("R1", {60'd0, taken, is_call, is_exit, illegal}, 64'd0, "idle flags");
        end
    endtask

    // one cycle: check outputs of last drive, then drive new inputs
    task automatic step(logic v, logic [3:0] c, logic ss, logic nar,
                        logic [63:0] d, logic [63:0] s, logic [31:0] im,
                        logic [15:0] off, logic [31:0] idx);
        @(negedge clk);
        compare();
        in_valid = v; op_code = c; src_sel = ss; is_jmp32 = nar;
        dst_val = d; src_val = s; imm = im; offset = off; cur_idx = idx;
        model();
    endtask

    function automatic logic [63:0] pick();
        case ($urandom_range(0, 9))
            0: return 64'd0;
            1: return 64'd1;
            2: return '1;
            3: return 64'h0000_0000_7FFF_FFFF;
            4: return 64'h0000_0000_8000_0000;
            5: return 64'h0000_0000_FFFF_FFFF;
            6: return 64'h8000_0000_0000_0000;
            7: return 64'hFFFF_FFFF_8000_0000;
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    logic done = 1'b0;

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // reset state (R1)
        repeat (3) @(negedge clk);
        chk("R1", {59'd0, out_valid, taken, is_call, is_exit, illegal}, 64'd0, "reset outputs");
        chk("R1", {32'd0, next_idx}, 64'd0, "reset next_idx");
        rst_n = 1'b1;
        // R2 equal, R3 unsigned vs R4 signed around the sign bit
        step(1, 4'h1, 1, 0, 64'd5, 64'd5, 0, 16'd3, 32'd10);
        step(1, 4'h2, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd4, 32'd20);
        step(1, 4'h6, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd4, 32'd20);
        step(1, 4'hC, 1, 0, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd4, 32'd20);
        // R7: upper halves differ, low halves equal / signed by bit 31
        step(1, 4'h1, 1, 1, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 0, 16'd1, 32'd0);
        step(1, 4'hC, 1, 1, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 0, 16'd1, 32'd0);
        // R6 immediate sign extension: wide equal, narrow equal, wide unequal
        step(1, 4'h1, 0, 0, '1, 0, 32'hFFFF_FFFF, 16'd2, 32'd7);
        step(1, 4'h1, 0, 1, 64'h0000_0000_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'd2, 32'd7);
        step(1, 4'h1, 0, 0, 64'h0000_0000_FFFF_FFFF, 0, 32'hFFFF_FFFF, 16'd2, 32'd7);
        // R5 bit test
        step(1, 4'h4, 1, 0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 16'd9, 32'd1);
        step(1, 4'h4, 1, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 16'd9, 32'd1);
        // R8 always, R9 wrap both directions
        step(1, 4'h0, 0, 0, 0, 0, 0, 16'hFFFF, 32'd0);
        step(1, 4'h0, 0, 0, 0, 0, 0, 16'hFFFE, 32'd0);
        step(1, 4'h0, 0, 0, 0, 0, 0, 16'h7FFF, 32'hFFFF_FFF0);
        // R10 call / return, R11 illegal encodings
        step(1, 4'h8, 0, 0, 0, 0, 0, 16'd5, 32'd3);
        step(1, 4'h8, 0, 1, 0, 0, 0, 16'd5, 32'd3);
        step(1, 4'h9, 0, 0, 0, 0, 0, 16'd5, 32'd3);
        step(1, 4'h9, 0, 1, 0, 0, 0, 16'd5, 32'd3);
        step(1, 4'h0, 0, 1, 0, 0, 0, 16'd5, 32'd3);
        step(1, 4'hE, 1, 0, 0, 0, 0, 16'd5, 32'd3);
        step(1, 4'hF, 1, 1, 0, 0, 0, 16'd5, 32'd3);
        step(0, 4'h1, 1, 0, 0, 0, 0, 16'd5, 32'd3);
        // mixed random with boundary-biased operands, idle gaps
        for (int i = 0; i < 4000; i++) begin
            step(($urandom_range(0, 7) != 0), 4'($urandom_range(0, 15)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 pick(), pick(), 32'(pick()), 16'($urandom()), $urandom());
        end
        step(0, 4'h0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 4'h0, 0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule